// File: doc/BRIEF.md
# Chip-Select Line Generator

This block drives a small set of chip-select pins for a serial-peripheral master under direct software control. Every line has two configuration bits: one that hands the line over to chip-select use, and one that inverts the level at the pin, so that a device wanting an active-high select idles low. Software asserts and releases lines by writing a force word. The upper half of that word carries per-line "go inactive" bits and the lower half carries per-line "go active" bits. A write therefore changes only the lines whose bits are 1, and software never has to read, modify and write the word back.

The block holds the logical state of every line. A logical 1 means inactive and a logical 0 means active. The block combines that state with the assignment and inversion bits and drives the pins. It also returns the pin levels as a status word. There are two register words, and each has its own select value. A write takes effect at the clock edge where it is presented, and the pins show the new level straight after that edge. The line count is a parameter from 1 to 8. Six is the full build and three is the reduced build.

Top module: `cs_line_gen`

## Requirements
- R1: After a synchronous active-low reset, every line holds logical 1, no line is assigned and no line is inverted. Every pin therefore reads 1.
- R2: A write with select 0 (configuration word) loads assignment bit n from data bit 8+n and invert bit n from data bit n. The new levels appear on the pins after that clock edge.
- R3: A write with select 1 (force word) with data bit 8+n = 1 and data bit n = 0 sets line n to logical 1 (inactive).
- R4: A force write with data bit n = 1 and data bit 8+n = 0 sets line n to logical 0 (active).
- R5: A force write with both bits of line n at 0 leaves line n unchanged.
- R6: A force write with both bits of line n at 1 leaves line n unchanged.
- R7: The pin of an assigned line equals its logical state XOR its invert bit. An inverted line therefore idles low and asserts high.
- R8: An unassigned line drives logical 1 XOR its invert bit. Its stored state is kept and reappears when the line is assigned again.
- R9: Bit n of the status word equals pin n. All bits at or above the line count read 0.
- R10: A force write of 0xFF00 puts every line in the logical inactive state.
- R11: Data bits that belong to no implemented line are ignored by both words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = configuration word, 1 = force word |
| wr_data_i | input | 16 | Write data |
| cs_pin_o | output | NUM_CS | Chip-select pin levels |
| stat_word_o | output | 16 | Pin levels, zero-extended |

## Verification
The assertions assume three things about the inputs. The write strobe, select and data are clean at each rising edge. Reset is held low for at least one edge before the first write. When the strobe is low, the select and data inputs may take any value. The stimulus drives every input on the falling edge, and it holds reset for three edges. It then mixes random select and data values, including random values while the strobe is idle. Directed writes cover both bits set for one line, both bits clear, the all-inactive word, and bits above the line count.

// File: rtl/cs_gen_pkg.sv
// Shared constants and types for the chip-select line generator.
// Assumes a 16-bit register word: the upper byte carries per-line
// control bits and the lower byte carries the companion bits.
package cs_gen_pkg;

    localparam int WORD_W  = 16;
    localparam int HI_BASE = 8;
    localparam int MAX_CS  = 8;

    typedef enum logic {
        SEL_CFG   = 1'b0,
        SEL_FORCE = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/cs_cfg_store.sv
// Configuration storage: one assignment bit and one invert bit per line.
// Assumes that the caller already holds the write strobe low for
// non-configuration writes. Bits beyond NUM_CS are never stored.
module cs_cfg_store #(
    parameter int NUM_CS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [NUM_CS-1:0] asg_bits_i,
    input  logic [NUM_CS-1:0] inv_bits_i,
    output logic [NUM_CS-1:0] asg_o,
    output logic [NUM_CS-1:0] inv_o
);

    // Load both fields on a configuration write; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asg_o <= '0;
            inv_o <= '0;
        end else if (wr_i) begin
            asg_o <= asg_bits_i;
            inv_o <= inv_bits_i;
        end
    end

    // R2: a configuration write is captured exactly.
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (asg_o == $past(asg_bits_i)) && (inv_o == $past(inv_bits_i)));

    // R2: without a write the configuration holds.
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(asg_o) && $stable(inv_o));

endmodule

// File: rtl/cs_line_state.sv
// Per-line logical state (1 = inactive, 0 = active), changed by force
// writes that carry separate set and clear groups. Assumes that the
// write strobe is asserted only for force-word writes.
module cs_line_state #(
    parameter int NUM_CS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [NUM_CS-1:0] set_i,
    input  logic [NUM_CS-1:0] clr_i,
    output logic [NUM_CS-1:0] state_o
);

    localparam logic [NUM_CS-1:0] ALL_IDLE = '1;

    for (genvar n = 0; n < NUM_CS; n++) begin : g_line
        logic go_idle;
        logic go_act;

        // Decode this line's request; a conflicting or empty pair is no request.
        always_comb begin
            go_idle = wr_i &&  set_i[n] && !clr_i[n];
            go_act  = wr_i && !set_i[n] &&  clr_i[n];
        end

        // Update the line's logical state; reset parks it inactive.
        always_ff @(posedge clk) begin
            if (!rst_n)       state_o[n] <= 1'b1;
            else if (go_idle) state_o[n] <= 1'b1;
            else if (go_act)  state_o[n] <= 1'b0;
        end

        // R3: a lone set bit drives the line inactive.
        p_set_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && set_i[n] && !clr_i[n]) |=> state_o[n]);

        // R4: a lone clear bit drives the line active.
        p_clr_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && clr_i[n] && !set_i[n]) |=> !state_o[n]);

        // R5: zero bits leave the line alone.
        p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && !set_i[n] && !clr_i[n]) |=> $stable(state_o[n]));

        // R6: both bits together leave the line alone.
        p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && set_i[n] && clr_i[n]) |=> $stable(state_o[n]));
    end

    // R10: a full set group with an empty clear group idles every line.
    p_all_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (set_i == ALL_IDLE) && (clr_i == '0)) |=> (state_o == ALL_IDLE));

endmodule

// File: rtl/cs_pin_map.sv
// Pin mapping: selects between a line's logical state and the idle level
// and then applies the per-line inversion. It also forms the zero-extended
// status word. Purely combinational.
module cs_pin_map #(
    parameter int NUM_CS = 6,
    parameter int WORD_W = 16
) (
    input  logic [NUM_CS-1:0] asg_i,
    input  logic [NUM_CS-1:0] inv_i,
    input  logic [NUM_CS-1:0] state_i,
    output logic [NUM_CS-1:0] pin_o,
    output logic [WORD_W-1:0] status_o
);

    localparam int PAD_W = WORD_W - NUM_CS;

    for (genvar n = 0; n < NUM_CS; n++) begin : g_pin
        logic lvl;
        // An unassigned line sits at its logical idle level before inversion.
        always_comb begin
            lvl      = asg_i[n] ? state_i[n] : 1'b1;
            pin_o[n] = lvl ^ inv_i[n];
        end
    end

    // Report the pin levels with the unused upper bits tied to zero.
    always_comb status_o = {{PAD_W{1'b0}}, pin_o};

endmodule

// File: rtl/cs_line_gen.sv
// Chip-select line generator (top level). It routes register writes to
// the configuration store and the line-state block and drives the pins
// through the pin map. Assumes NUM_CS lies in 1..8, so that the upper-byte
// fields fit the 16-bit word. Reset is synchronous and active low.
module cs_line_gen
    import cs_gen_pkg::*;
#(
    parameter int NUM_CS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [15:0]       wr_data_i,
    output logic [NUM_CS-1:0] cs_pin_o,
    output logic [15:0]       stat_word_o
);

    reg_sel_e          sel;
    logic              wr_cfg;
    logic              wr_force;
    logic [NUM_CS-1:0] hi_field;
    logic [NUM_CS-1:0] lo_field;
    logic [NUM_CS-1:0] asg;
    logic [NUM_CS-1:0] inv;
    logic [NUM_CS-1:0] state;

    // Decode the target word and split the data into its two line fields.
    always_comb begin
        sel      = reg_sel_e'(wr_sel_i);
        wr_cfg   = wr_en_i && (sel == SEL_CFG);
        wr_force = wr_en_i && (sel == SEL_FORCE);
        hi_field = wr_data_i[HI_BASE +: NUM_CS];
        lo_field = wr_data_i[0 +: NUM_CS];
    end

    cs_cfg_store #(.NUM_CS(NUM_CS)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_cfg),
        .asg_bits_i (hi_field),
        .inv_bits_i (lo_field),
        .asg_o      (asg),
        .inv_o      (inv)
    );

    cs_line_state #(.NUM_CS(NUM_CS)) state_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_force),
        .set_i   (hi_field),
        .clr_i   (lo_field),
        .state_o (state)
    );

    cs_pin_map #(.NUM_CS(NUM_CS), .WORD_W(WORD_W)) map_i (
        .asg_i    (asg),
        .inv_i    (inv),
        .state_i  (state),
        .pin_o    (cs_pin_o),
        .status_o (stat_word_o)
    );

    // R1: one cycle of reset leaves every pin high.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cs_pin_o == '1));

    for (genvar n = 0; n < NUM_CS; n++) begin : g_chk
        // R8: an unassigned line shows only its inverted idle level.
        p_unassigned_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !wr_sel_i && !wr_data_i[HI_BASE+n])
                |=> (cs_pin_o[n] == !$past(wr_data_i[n])));

        // R7: a force clear on an assigned line makes its pin equal the invert bit.
        p_active_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_sel_i && wr_data_i[n] && !wr_data_i[HI_BASE+n] && asg[n])
                |=> (cs_pin_o[n] == $past(inv[n])));
    end

endmodule

// File: tb/cs_line_gen_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random writes.
module cs_line_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 6;
    localparam int WD_CYCLES  = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [15:0]  wr_data = '0;
    logic [N-1:0] cs_pin;
    logic [15:0]  stat_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_asg;
    logic [N-1:0] m_inv;
    logic [N-1:0] m_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_line_gen #(.NUM_CS(N)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .cs_pin_o    (cs_pin),
        .stat_word_o (stat_word)
    );

    function automatic logic [N-1:0] exp_pins();
        logic [N-1:0] p;
        for (int n = 0; n < N; n++)
            p[n] = (m_asg[n] ? m_st[n] : 1'b1) ^ m_inv[n];
        return p;
    endfunction

    function automatic void model_write(input logic sel, input logic [15:0] d);
        if (!sel) begin
            m_asg = d[8 +: N];
            m_inv = d[0 +: N];
        end else begin
            for (int n = 0; n < N; n++) begin
                if (d[8+n] && !d[n])      m_st[n] = 1'b1;
                else if (d[n] && !d[8+n]) m_st[n] = 1'b0;
            end
        end
    endfunction

    task automatic check(input string tag);
        logic [N-1:0] ep;
        logic [15:0]  es;
        ep = exp_pins();
        es = {{(16-N){1'b0}}, ep};
        checks++;
        if (cs_pin !== ep) begin
            errors++;
            $display("FAIL %s pins actual=%b expected=%b", tag, cs_pin, ep);
        end
        checks++;
        if (stat_word !== es) begin
            errors++;
            $display("FAIL %s status actual=%h expected=%h", tag, stat_word, es);
        end
    endtask

    // Drive one write on the falling edge; it lands at the next rising edge.
    task automatic do_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        model_write(sel, d);
        @(negedge clk);
        wr_en = 1'b0;
        wr_sel = 1'($urandom);
        wr_data = 16'($urandom);
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_asg = '0; m_inv = '0; m_st = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");

        do_write(1'b0, 16'h3F00); check("R2 assign all lines");
        do_write(1'b1, 16'h0004); check("R4 clear line 2");
        do_write(1'b1, 16'h0400); check("R3 set line 2");
        do_write(1'b1, 16'h0003); check("R4 clear lines 0 and 1");
        do_write(1'b1, 16'h0000); check("R5 zero force word holds");
        do_write(1'b1, 16'h0101); check("R6 set and clear together hold line 0");
        do_write(1'b1, 16'h1010); check("R6 set and clear together hold line 4");
        do_write(1'b0, 16'h3F08); check("R7 inverted line idles low");
        do_write(1'b1, 16'h0008); check("R7 inverted line asserts high");
        do_write(1'b0, 16'h3D08); check("R8 unassigned line at idle level");
        do_write(1'b0, 16'h3F08); check("R8 reassigned line shows kept state");
        do_write(1'b1, 16'hFF00); check("R10 all lines inactive");
        do_write(1'b1, 16'h003F); check("R4 all lines active");
        do_write(1'b1, 16'hC0C0); check("R11 force bits above line count ignored");
        do_write(1'b0, 16'hC0C0); check("R11 config bits above line count ignored");
        do_write(1'b0, 16'h2A15); check("R9 status mirrors mixed pins");

        for (int i = 0; i < 400; i++) begin
            if ((i % 8) == 0) do_write(1'b0, 16'($urandom));
            else              do_write(1'b1, 16'($urandom));
            check("R9 random status and R7 pin level");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule